// File: doc/BRIEF.md
# ICMP Echo Responder

This block answers ping requests at the Ethernet layer. Frames arrive one byte per beat on an AXI4-Stream slave port and end on TLAST. Each frame is captured in an internal buffer while a classifier checks that it is an IPv4 ICMP echo request addressed to the local address. A ones'-complement accumulator builds the reply checksum during the same pass.

When a matching frame has fully arrived, the block streams the reply out on an AXI4-Stream master port. The reply is the stored frame with these changes: the two MAC addresses are swapped, the two IPv4 addresses are swapped, the ICMP type is set to echo reply, and a fresh ICMP checksum is inserted. Frames that do not match, are too short, or do not fit in the buffer produce no output. The block holds one frame at a time, and its input is stalled while a reply is being sent.

Top module: `icmp_echo_responder`

## Requirements
- R1: After reset the input accepts data (s_tready=1) and no reply is pending (m_tvalid=0). A reset asserted while a reply is being sent discards that reply.
- R2: The reply to an accepted frame starts only after the input beat carrying TLAST. It has the same byte count as the request and ends with m_tlast on its final byte. No output is valid while a frame is being received.
- R3: Reply bytes 0..5 carry request bytes 6..11, and reply bytes 6..11 carry request bytes 0..5 (MAC swap).
- R4: Reply bytes 26..29 carry request bytes 30..33, and reply bytes 30..33 carry request bytes 26..29 (IPv4 address swap).
- R5: Reply byte 34 (ICMP type) is 0x00. Reply byte 35 (ICMP code) and every byte not named in R3, R4 or R5 equal the request byte at the same offset.
- R6: Reply bytes 36 and 37 hold the ones' complement of the ones'-complement sum of the reply's 16-bit big-endian words, taken from byte 34 to the end of the frame. Bytes 34, 36 and 37 count as zero in that sum, carries out of bit 15 are folded back, and byte 36 holds the high byte. The request's own checksum bytes have no effect.
- R7: An ICMP section of odd length is summed as if a zero low byte followed its last byte.
- R8: A frame is accepted only if all of these hold: bytes 12..13 = 0x08,0x00; byte 14 = 0x45; byte 23 = 0x01; byte 34 = 0x08; bytes 30..33 equal local_ip[7:0], [15:8], [23:16], [31:24] in that order (the first octet sits in the least-significant byte). Any other frame produces no output.
- R9: Frames shorter than 38 bytes or longer than DEPTH bytes produce no output. A frame of exactly DEPTH bytes is answered.
- R10: While m_tvalid=1 and m_tready=0, m_tvalid stays high and m_tdata and m_tlast hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| local_ip | input | 32 | Local IPv4 address, first octet in bits 7:0 |
| s_tdata | input | 8 | Request stream byte |
| s_tvalid | input | 1 | Request byte valid |
| s_tready | output | 1 | Block can take a request byte |
| s_tlast | input | 1 | Last byte of the request frame |
| m_tdata | output | 8 | Reply stream byte |
| m_tvalid | output | 1 | Reply byte valid |
| m_tready | input | 1 | Downstream takes the reply byte |
| m_tlast | output | 1 | Last byte of the reply frame |

## Verification
A classifier flag left stale from a previous frame would turn up at the next TLAST, as a reply to a bad frame or as silence after a good one. The vector table therefore mixes accepted frames with frames that fail one field each. A checksum accumulator that is not cleared, or whose end-around carry is wrong, would corrupt bytes 36 and 37 of the very next reply. Frames whose payloads force carries, and frames of odd length, expose that. An off-by-one in the read pointer or the byte remap would show inside the same reply as shifted MAC or IP bytes or a wrong length. Random-looking stalls on m_tready check that the output holds still under backpressure.

// File: rtl/icmp_echo_pkg.sv
`timescale 1ns/1ps
// Package: byte offsets and field values shared by the echo responder.
// Assumes untagged Ethernet II framing and an IPv4 header with no options.
package icmp_echo_pkg;
    localparam int MAC_BYTES       = 6;
    localparam int IP_BYTES        = 4;
    localparam int OFS_TYPE_HI     = 12;
    localparam int OFS_TYPE_LO     = 13;
    localparam int OFS_VER_IHL     = 14;
    localparam int OFS_PROTO       = 23;
    localparam int OFS_IP_SRC      = 26;
    localparam int OFS_IP_DST      = 30;
    localparam int OFS_ICMP        = 34;
    localparam int OFS_ICMP_SUM    = 36;
    localparam int MIN_FRAME_BYTES = 38;

    localparam logic [7:0] ETYPE_HI_VAL = 8'h08;
    localparam logic [7:0] ETYPE_LO_VAL = 8'h00;
    localparam logic [7:0] VER_IHL_VAL  = 8'h45;
    localparam logic [7:0] PROTO_ICMP   = 8'h01;
    localparam logic [7:0] ICMP_REQUEST = 8'h08;
    localparam logic [7:0] ICMP_REPLY   = 8'h00;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_SEND = 1'b1
    } resp_state_t;
endpackage

// File: rtl/icmp_frame_store.sv
`timescale 1ns/1ps
// Module: single-frame byte buffer, one write port and one combinational
// read port. Assumes the writer never presents an address >= DEPTH.
module icmp_frame_store #(
    parameter int DEPTH = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write the incoming byte into its slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // A stored byte is readable at its address on the next cycle (R3, R5).
    assert_store_holds_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/icmp_frame_classifier.sv
`timescale 1ns/1ps
// Module: checks, byte by byte, that a frame is an IPv4 ICMP echo request
// for the local address. frame_ok is valid on the beat that carries TLAST.
// Assumes idx is the byte offset of the current beat.
module icmp_frame_classifier
    import icmp_echo_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          last,
    input  logic [PW-1:0] idx,
    input  logic [7:0]    data,
    input  logic [31:0]   local_ip,
    output logic          frame_ok
);
    logic match_now;
    logic match_q;

    // Compare the current byte with the value expected at its offset.
    always_comb begin
        match_now = 1'b1;
        if      (idx == PW'(OFS_TYPE_HI))    match_now = (data == ETYPE_HI_VAL);
        else if (idx == PW'(OFS_TYPE_LO))    match_now = (data == ETYPE_LO_VAL);
        else if (idx == PW'(OFS_VER_IHL))    match_now = (data == VER_IHL_VAL);
        else if (idx == PW'(OFS_PROTO))      match_now = (data == PROTO_ICMP);
        else if (idx == PW'(OFS_IP_DST))     match_now = (data == local_ip[7:0]);
        else if (idx == PW'(OFS_IP_DST + 1)) match_now = (data == local_ip[15:8]);
        else if (idx == PW'(OFS_IP_DST + 2)) match_now = (data == local_ip[23:16]);
        else if (idx == PW'(OFS_IP_DST + 3)) match_now = (data == local_ip[31:24]);
        else if (idx == PW'(OFS_ICMP))       match_now = (data == ICMP_REQUEST);
    end

    // Accumulate the match result over the frame; re-arm at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b1;
        end else if (beat) begin
            match_q <= last ? 1'b1 : (match_q & match_now);
        end
    end

    assign frame_ok = match_q & match_now;

    // Each new frame starts with a clean match flag (R8).
    assert_rearm_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> match_q);
endmodule

// File: rtl/icmp_csum_acc.sv
`timescale 1ns/1ps
// Module: running ones'-complement sum of the reply's ICMP section, built
// while the request streams in. The type byte and the checksum bytes count
// as zero. Even offsets are high bytes, odd offsets low bytes. The final
// complemented sum is latched on TLAST and held until the next frame ends.
module icmp_csum_acc
    import icmp_echo_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add,
    input  logic          last,
    input  logic [PW-1:0] idx,
    input  logic [7:0]    data,
    output logic [15:0]   result
);
    logic [15:0] acc_q;
    logic [15:0] result_q;
    logic [15:0] contrib;
    logic [16:0] sum_wide;
    logic [15:0] acc_next;
    logic        in_icmp;

    assign in_icmp = (idx > PW'(OFS_ICMP)) &&
                     (idx != PW'(OFS_ICMP_SUM)) && (idx != PW'(OFS_ICMP_SUM + 1));

    // Place the byte in the high or low half of its 16-bit word.
    always_comb begin
        contrib = 16'h0000;
        if (in_icmp) contrib = idx[0] ? {8'h00, data} : {data, 8'h00};
    end

    assign sum_wide = {1'b0, acc_q} + {1'b0, contrib};
    assign acc_next = sum_wide[15:0] + {15'd0, sum_wide[16]};

    // Add each byte with end-around carry; close the sum on TLAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= 16'h0000;
            result_q <= 16'hFFFF;
        end else if (add) begin
            if (last) begin
                result_q <= ~acc_next;
                acc_q    <= 16'h0000;
            end else begin
                acc_q    <= acc_next;
            end
        end
    end

    assign result = result_q;

    // Header bytes ahead of the ICMP section leave the sum alone (R6).
    assert_header_not_summed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !last && idx <= PW'(OFS_ICMP)) |=> $stable(acc_q));
    // The closed sum does not change while no frame is arriving (R6).
    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !add |=> $stable(result_q));
endmodule

// File: rtl/icmp_echo_responder.sv
`timescale 1ns/1ps
// Module: top of the ICMP echo responder. It captures one byte-wide frame,
// classifies it, and sums its ICMP section. On an accepted TLAST it replays
// the frame with swapped addresses, type 0 and the new checksum. It assumes
// untagged Ethernet II and IPv4 without options. The input stalls while a
// reply is being sent.
module icmp_echo_responder
    import icmp_echo_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] local_ip,
    input  logic [7:0]  s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic        s_tlast,
    output logic [7:0]  m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    resp_state_t   state_q;
    logic [PW-1:0] wr_idx_q;
    logic [PW-1:0] rd_idx_q;
    logic [PW-1:0] tx_len_q;
    logic          ovf_q;
    logic          beat;
    logic          stored;
    logic          frame_ok;
    logic          accept;
    logic          send_beat;
    logic [15:0]   csum;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] rd_lo;
    logic [7:0]    mem_rdata;

    assign s_tready  = (state_q == ST_RECV);
    assign beat      = s_tvalid && s_tready;
    assign stored    = wr_idx_q < PW'(DEPTH);
    assign accept    = frame_ok && !ovf_q && stored &&
                       (wr_idx_q >= PW'(MIN_FRAME_BYTES - 1));
    assign m_tvalid  = (state_q == ST_SEND);
    assign m_tlast   = m_tvalid && (rd_idx_q == tx_len_q - PW'(1));
    assign send_beat = m_tvalid && m_tready;

    // Track the write offset and note bytes that fall beyond the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q <= '0;
            ovf_q    <= 1'b0;
        end else if (beat) begin
            if (s_tlast) begin
                wr_idx_q <= '0;
                ovf_q    <= 1'b0;
            end else if (stored) begin
                wr_idx_q <= wr_idx_q + PW'(1);
            end else begin
                ovf_q    <= 1'b1;
            end
        end
    end

    // Switch between receiving and replaying; step the replay pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RECV;
            rd_idx_q <= '0;
            tx_len_q <= '0;
        end else begin
            case (state_q)
                ST_RECV: begin
                    if (beat && s_tlast && accept) begin
                        state_q  <= ST_SEND;
                        tx_len_q <= wr_idx_q + PW'(1);
                        rd_idx_q <= '0;
                    end
                end
                ST_SEND: begin
                    if (send_beat) begin
                        if (m_tlast) state_q  <= ST_RECV;
                        else         rd_idx_q <= rd_idx_q + PW'(1);
                    end
                end
                default: state_q <= ST_RECV;
            endcase
        end
    end

    // Map a reply offset to the request offset it copies (address swaps).
    assign rd_lo = rd_idx_q[AW-1:0];
    always_comb begin
        rd_addr = rd_lo;
        if (rd_idx_q < PW'(MAC_BYTES))
            rd_addr = rd_lo + AW'(MAC_BYTES);
        else if (rd_idx_q < PW'(2 * MAC_BYTES))
            rd_addr = rd_lo - AW'(MAC_BYTES);
        else if (rd_idx_q >= PW'(OFS_IP_SRC) && rd_idx_q < PW'(OFS_IP_DST))
            rd_addr = rd_lo + AW'(IP_BYTES);
        else if (rd_idx_q >= PW'(OFS_IP_DST) && rd_idx_q < PW'(OFS_IP_DST + IP_BYTES))
            rd_addr = rd_lo - AW'(IP_BYTES);
    end

    // Overlay the reply type and the new checksum on the stored bytes.
    always_comb begin
        m_tdata = mem_rdata;
        if      (rd_idx_q == PW'(OFS_ICMP))         m_tdata = ICMP_REPLY;
        else if (rd_idx_q == PW'(OFS_ICMP_SUM))     m_tdata = csum[15:8];
        else if (rd_idx_q == PW'(OFS_ICMP_SUM + 1)) m_tdata = csum[7:0];
    end

    icmp_frame_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (beat && stored),
        .waddr (wr_idx_q[AW-1:0]),
        .wdata (s_tdata),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    icmp_frame_classifier #(.PW(PW)) u_classify (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (beat),
        .last     (s_tlast),
        .idx      (wr_idx_q),
        .data     (s_tdata),
        .local_ip (local_ip),
        .frame_ok (frame_ok)
    );

    icmp_csum_acc #(.PW(PW)) u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .add    (beat),
        .last   (s_tlast),
        .idx    (wr_idx_q),
        .data   (s_tdata),
        .result (csum)
    );

    // A rejected frame end never starts a reply (R8, R9).
    assert_drop_is_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && s_tlast && !accept) |=> !m_tvalid);
    // A stalled reply byte stays put (R10).
    assert_hold_under_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
    // The reply keeps going until its last byte is taken (R2).
    assert_reply_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send_beat && !m_tlast) |=> m_tvalid);
    // After the final reply byte the input reopens (R2).
    assert_reopen_after_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send_beat && m_tlast) |=> (s_tready && !m_tvalid));
endmodule

// File: tb/icmp_echo_responder_test.sv
`timescale 1ns/1ps
module icmp_echo_responder_test;
    localparam int DEPTH = 128;
    localparam logic [31:0] MY_IP = 32'h0200A8C0;

    typedef struct packed {
        logic [7:0]  len;
        logic [15:0] etype;
        logic [7:0]  vihl;
        logic [7:0]  proto;
        logic [7:0]  itype;
        logic        ipok;
        logic        want;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'd42,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b1},  // even ICMP length
        '{8'd43,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b1},  // odd ICMP length (R7)
        '{8'd98,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b1},  // 64-byte ICMP section
        '{8'd38,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b1},  // minimum length (R9)
        '{8'd60,  16'h86DD, 8'h45, 8'h01, 8'h08, 1'b1, 1'b0},  // wrong ethertype
        '{8'd60,  16'h0800, 8'h45, 8'h06, 8'h08, 1'b1, 1'b0},  // wrong protocol
        '{8'd60,  16'h0800, 8'h45, 8'h01, 8'h00, 1'b1, 1'b0},  // already a reply
        '{8'd60,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b0, 1'b0},  // not our address
        '{8'd60,  16'h0800, 8'h46, 8'h01, 8'h08, 1'b1, 1'b0},  // IP options present
        '{8'd37,  16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b0},  // too short (R9)
        '{8'd128, 16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b1},  // exactly DEPTH (R9)
        '{8'd129, 16'h0800, 8'h45, 8'h01, 8'h08, 1'b1, 1'b0}   // one byte too many (R9)
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] s_tdata = '0;
    logic       s_tvalid = 1'b0;
    logic       s_tready;
    logic       s_tlast = 1'b0;
    logic [7:0] m_tdata;
    logic       m_tvalid;
    logic       m_tready = 1'b0;
    logic       m_tlast;

    always #2.5 clk = ~clk;

    icmp_echo_responder #(.DEPTH(DEPTH)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .local_ip (MY_IP),
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .s_tlast  (s_tlast),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tlast  (m_tlast)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0] tx_frame  [256];
    logic [7:0] exp_frame [256];
    logic [7:0] rx_frame  [256];
    int rx_len;
    int stall_err;
    int early_err;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic build(input vec_t v, input int seed);
        for (int i = 0; i < 256; i++) tx_frame[i] = 8'(i * 37 + seed * 53 + 17 + (i * i) % 251);
        tx_frame[12] = v.etype[15:8];
        tx_frame[13] = v.etype[7:0];
        tx_frame[14] = v.vihl;
        tx_frame[23] = v.proto;
        tx_frame[30] = v.ipok ? MY_IP[7:0]   : 8'h0A;
        tx_frame[31] = v.ipok ? MY_IP[15:8]  : 8'h00;
        tx_frame[32] = v.ipok ? MY_IP[23:16] : 8'h00;
        tx_frame[33] = v.ipok ? MY_IP[31:24] : 8'h09;
        tx_frame[34] = v.itype;
    endtask

    task automatic make_expected(input int n);
        int s;
        for (int i = 0; i < n; i++) exp_frame[i] = tx_frame[i];
        for (int i = 0; i < 6; i++) begin
            exp_frame[i]     = tx_frame[i + 6];
            exp_frame[i + 6] = tx_frame[i];
        end
        for (int i = 0; i < 4; i++) begin
            exp_frame[26 + i] = tx_frame[30 + i];
            exp_frame[30 + i] = tx_frame[26 + i];
        end
        exp_frame[34] = 8'h00;
        exp_frame[36] = 8'h00;
        exp_frame[37] = 8'h00;
        s = 0;
        for (int i = 34; i < n; i++) s += (i % 2 == 0) ? int'(exp_frame[i]) << 8 : int'(exp_frame[i]);
        while ((s >> 16) != 0) s = (s & 16'hFFFF) + (s >> 16);
        s = ~s & 16'hFFFF;
        exp_frame[36] = 8'(s >> 8);
        exp_frame[37] = 8'(s);
    endtask

    task automatic send(input int n);
        early_err = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_tvalid) early_err++;
            s_tvalid = 1'b1;
            s_tdata  = tx_frame[i];
            s_tlast  = (i == n - 1);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic collect(input int max_idle);
        int idle = 0;
        int cyc = 0;
        logic done = 1'b0;
        logic have_stall = 1'b0;
        logic [7:0] st_d = '0;
        rx_len = 0;
        stall_err = 0;
        while (!done && idle < max_idle) begin
            if (cyc > 0) @(negedge clk);
            m_tready = ((cyc % 3) != 2) && ((cyc % 7) != 4);
            cyc++;
            if (have_stall) begin
                if (!m_tvalid || m_tdata != st_d) stall_err++;
                have_stall = 1'b0;
            end
            if (m_tvalid) begin
                idle = 0;
                if (m_tready) begin
                    if (rx_len < 256) rx_frame[rx_len] = m_tdata;
                    rx_len++;
                    if (m_tlast) done = 1'b1;
                end else begin
                    have_stall = 1'b1;
                    st_d = m_tdata;
                end
            end else begin
                idle++;
            end
        end
        @(negedge clk);
        m_tready = 1'b0;
    endtask

    task automatic run_vector(input vec_t v, input int k);
        int mis;
        int n;
        n = int'(v.len);
        build(v, k);
        send(n);
        chk($sformatf("R2 no output while receiving, vec %0d", k), early_err, 0);
        collect(v.want ? 40 : 20);
        if (!v.want) begin
            chk($sformatf("R8 R9 dropped frame gives no output, vec %0d", k), rx_len, 0);
            chk($sformatf("R8 input reopened after drop, vec %0d", k), int'(s_tready), 1);
            return;
        end
        make_expected(n);
        chk($sformatf("R2 reply length, vec %0d", k), rx_len, n);
        chk($sformatf("R10 stalled byte held, vec %0d", k), stall_err, 0);
        if (rx_len != n) return;
        mis = 0;
        for (int i = 0; i < 12; i++) if (rx_frame[i] != exp_frame[i]) mis++;
        chk($sformatf("R3 MAC swap mismatches, vec %0d", k), mis, 0);
        mis = 0;
        for (int i = 26; i < 34; i++) if (rx_frame[i] != exp_frame[i]) mis++;
        chk($sformatf("R4 IP swap mismatches, vec %0d", k), mis, 0);
        chk($sformatf("R5 ICMP type byte, vec %0d", k), int'(rx_frame[34]), 0);
        mis = 0;
        for (int i = 12; i < n; i++)
            if ((i < 26 || i > 33) && i != 34 && i != 36 && i != 37 && rx_frame[i] != exp_frame[i]) mis++;
        chk($sformatf("R5 untouched byte mismatches, vec %0d", k), mis, 0);
        chk($sformatf("%s checksum, vec %0d", ((n - 34) % 2 != 0) ? "R7 odd-length" : "R6", k),
            int'({rx_frame[36], rx_frame[37]}), int'({exp_frame[36], exp_frame[37]}));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 m_tvalid in reset", int'(m_tvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 s_tready after reset", int'(s_tready), 1);
        chk("R1 m_tvalid after reset", int'(m_tvalid), 0);

        for (int k = 0; k < NVEC; k++) run_vector(VECS[k], k);

        // Directed: reset while a reply waits under backpressure.
        build(VECS[0], 50);
        send(int'(VECS[0].len));
        repeat (3) @(negedge clk);
        chk("R10 reply pending under stall", int'(m_tvalid), 1);
        chk("R2 input blocked while reply pending", int'(s_tready), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset discards pending reply", int'(m_tvalid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 input open after mid-reply reset", int'(s_tready), 1);
        collect(10);
        chk("R1 no stale reply after reset", rx_len, 0);

        // Directed: a good frame right after the reset is answered in full.
        run_vector(VECS[1], 61);

        // Directed: checksum of all-0xFF payload forces end-around carries.
        build(VECS[2], 7);
        for (int i = 38; i < 98; i++) tx_frame[i] = 8'hFF;
        send(98);
        collect(40);
        make_expected(98);
        chk("R2 carry frame length", rx_len, 98);
        chk("R6 checksum with folded carries",
            int'({rx_frame[36], rx_frame[37]}), int'({exp_frame[36], exp_frame[37]}));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule